// File: doc/BRIEF.md
# Frame Capture Buffer Controller

This block takes pixel bytes from a camera port and stores one frame of them in an on-chip byte buffer. Software works through a small byte-wide register port. It arms a capture, waits for the done flag, reads the stored byte count, and then drains the buffer one byte per read. The write side and the read side each have their own pointer, and each pointer can be reset on its own.

The control flow is a four-state machine:
- `ST_IDLE` moves to `ST_ARMED` on a start command.
- `ST_ARMED` moves to `ST_CAPTURE` on the next rising edge of vsync.
- `ST_CAPTURE` moves to `ST_DONE` on the next rising edge of vsync.
- `ST_DONE` moves back to `ST_IDLE` on a clear command, or to `ST_ARMED` on a new start command.

A byte is stored in every `ST_CAPTURE` cycle that carries a valid pixel, except the cycle of the closing vsync edge. The stored-byte count saturates at the buffer depth, and bytes beyond that depth are dropped.

Top module: `frame_capture_ctrl`

## Requirements
- R1: After reset the status register reads zero while vsync and shutter are low, all three size registers read zero, and the done flag is clear.
- R2: The status register at address 0x41 shows live vsync in bit 0, the shutter input in bit 1 and the capture-done flag in bit 3. Its other bits read zero.
- R3: Writing a value with bit 1 set to the control register at 0x04 arms a capture. Pixel bytes that arrive while the block is idle or armed are not stored. Storing begins in the cycle after the next vsync rising edge.
- R4: The next vsync rising edge after storing begins ends the capture and sets the done flag. A pixel byte that arrives in that edge cycle is not stored.
- R5: The done flag stays set until a control write with bit 0 set (clear) or bit 1 set (start) is made.
- R6: A start command that is written while the block is armed or capturing is ignored, and the capture under way completes normally.
- R7: A control write with bit 4 set resets the write pointer and zeroes the byte count. The byte count saturates at DEPTH, and further bytes are dropped.
- R8: The byte count is read as a low byte at 0x42, a middle byte at 0x43 and a high byte at 0x44. Bit 7 of the high byte always reads zero, which makes the count 23 bits wide.
- R9: A read strobe at address 0x3D returns the stored byte under the read pointer and then advances the pointer, wrapping after DEPTH bytes. A control write with bit 5 set returns the read pointer to the first byte.
- R10: Addresses that are not mapped read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cam_vsync | input | 1 | Frame sync from the camera; a rising edge marks a frame boundary |
| cam_shutter | input | 1 | Shutter input, shown in status |
| cam_valid | input | 1 | Pixel byte valid |
| cam_data | input | 8 | Pixel byte |
| reg_addr | input | 7 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops data at 0x3D) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |

## Verification
The bench builds the block with DEPTH set to 300. This depth is not a power of two, so the read pointer's wrap path and the saturation path are both reached with frames a few hundred bytes long. The depth also puts a nonzero value into the middle size byte (300 is 0x012C), so the byte order of the three size registers is observable. Randomly sized frames with idle gaps are mixed with a directed frame that runs past the depth.

// File: rtl/fcap_pkg.sv
package fcap_pkg;

    localparam int COUNT_W = 23;

    localparam logic [6:0] ADDR_CTRL    = 7'h04;
    localparam logic [6:0] ADDR_STATUS  = 7'h41;
    localparam logic [6:0] ADDR_SIZE_LO = 7'h42;
    localparam logic [6:0] ADDR_SIZE_MD = 7'h43;
    localparam logic [6:0] ADDR_SIZE_HI = 7'h44;
    localparam logic [6:0] ADDR_DATA    = 7'h3D;

    localparam int BIT_CLEAR  = 0;
    localparam int BIT_START  = 1;
    localparam int BIT_RST_WR = 4;
    localparam int BIT_RST_RD = 5;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_DONE    = 2'd3
    } cap_state_t;

endpackage

// File: rtl/fcap_fsm.sv
module fcap_fsm
    import fcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vsync,
    input  logic       pix_valid,
    input  logic       start,
    input  logic       clear,
    output cap_state_t state,
    output logic       store_en,
    output logic       done
);

    logic       vsync_q;
    logic       vsync_rise;
    cap_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) vsync_q <= 1'b0;
        else        vsync_q <= vsync;
    end

    assign vsync_rise = vsync & ~vsync_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:    if (start)      state_d = ST_ARMED;
            ST_ARMED:   if (vsync_rise) state_d = ST_CAPTURE;
            ST_CAPTURE: if (vsync_rise) state_d = ST_DONE;
            ST_DONE: begin
                if (start)      state_d = ST_ARMED;
                else if (clear) state_d = ST_IDLE;
            end
            default:            state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        store_en = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_CAPTURE: store_en = pix_valid & ~vsync_rise;
            ST_DONE:    done     = 1'b1;
            default:    ;
        endcase
    end

    // R6: a start inside a capture does not leave the capture early
    a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE && !(vsync && !vsync_q)) |=> state == ST_CAPTURE);

    // R6: an armed block waits for vsync whatever else is written
    a_r6_armed_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !(vsync && !vsync_q)) |=> state == ST_ARMED);

    // R5: done holds until clear or start
    a_r5_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !start && !clear) |=> done);

endmodule

// File: rtl/fcap_store.sv
module fcap_store
    import fcap_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               store_en,
    input  logic [7:0]         pix_data,
    input  logic               rst_wr,
    input  logic               rst_rd,
    input  logic               pop,
    output logic [COUNT_W-1:0] count,
    output logic [7:0]         rd_data
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [COUNT_W-1:0] FULL = COUNT_W'(DEPTH);
    localparam logic [AW-1:0]      LAST = AW'(DEPTH - 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          accept;

    assign accept  = store_en && (count < FULL);
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept && !rst_wr) mem[wr_ptr] <= pix_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || rst_wr) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (accept) begin
            wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
            count  <= count + COUNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || rst_rd) rd_ptr <= '0;
        else if (pop)         rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
    end

    // R7: count never passes the depth
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);

    // R7: write-pointer reset empties the count
    a_r7_rst_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rst_wr |=> count == '0);

    // R7: one stored byte adds exactly one
    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (store_en && !rst_wr && count < FULL) |=> count == $past(count) + COUNT_W'(1));

endmodule

// File: rtl/fcap_regs.sv
module fcap_regs
    import fcap_pkg::*;
(
    input  logic [6:0]         addr,
    input  logic               wr,
    input  logic               rd,
    input  logic [7:0]         wdata,
    input  logic               vsync,
    input  logic               shutter,
    input  logic               done,
    input  logic [COUNT_W-1:0] count,
    input  logic [7:0]         buf_data,
    output logic               start,
    output logic               clear,
    output logic               rst_wr,
    output logic               rst_rd,
    output logic               pop,
    output logic [7:0]         rdata
);

    logic ctrl_wr;
    logic [23:0] cnt24;

    assign ctrl_wr = wr && (addr == ADDR_CTRL);
    assign start   = ctrl_wr && wdata[BIT_START];
    assign clear   = ctrl_wr && wdata[BIT_CLEAR];
    assign rst_wr  = ctrl_wr && wdata[BIT_RST_WR];
    assign rst_rd  = ctrl_wr && wdata[BIT_RST_RD];
    assign pop     = rd && (addr == ADDR_DATA);
    assign cnt24   = 24'(count);

    always_comb begin
        unique case (addr)
            ADDR_STATUS:  rdata = {4'b0, done, 1'b0, shutter, vsync};
            ADDR_SIZE_LO: rdata = cnt24[7:0];
            ADDR_SIZE_MD: rdata = cnt24[15:8];
            ADDR_SIZE_HI: rdata = {1'b0, cnt24[22:16]};
            ADDR_DATA:    rdata = buf_data;
            default:      rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/frame_capture_ctrl.sv
module frame_capture_ctrl
    import fcap_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cam_vsync,
    input  logic       cam_shutter,
    input  logic       cam_valid,
    input  logic [7:0] cam_data,
    input  logic [6:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata
);

    cap_state_t         state;
    logic               store_en, done;
    logic               start, clear, rst_wr, rst_rd, pop;
    logic [COUNT_W-1:0] count;
    logic [7:0]         buf_data;

    fcap_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .vsync    (cam_vsync),
        .pix_valid(cam_valid),
        .start    (start),
        .clear    (clear),
        .state    (state),
        .store_en (store_en),
        .done     (done)
    );

    fcap_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .store_en(store_en),
        .pix_data(cam_data),
        .rst_wr  (rst_wr),
        .rst_rd  (rst_rd),
        .pop     (pop),
        .count   (count),
        .rd_data (buf_data)
    );

    fcap_regs u_regs (
        .addr    (reg_addr),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .wdata   (reg_wdata),
        .vsync   (cam_vsync),
        .shutter (cam_shutter),
        .done    (done),
        .count   (count),
        .buf_data(buf_data),
        .start   (start),
        .clear   (clear),
        .rst_wr  (rst_wr),
        .rst_rd  (rst_rd),
        .pop     (pop),
        .rdata   (reg_rdata)
    );

    // R4: the count is frozen once the frame has ended
    a_r4_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !rst_wr) |=> count == $past(count));

endmodule

// File: tb/tb_frame_capture_ctrl.sv
`timescale 1ns/1ps
module tb_frame_capture_ctrl;

    localparam int DEPTH = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cam_vsync = 1'b0, cam_shutter = 1'b0, cam_valid = 1'b0;
    logic [7:0] cam_data = '0;
    logic [6:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;

    int n_chk = 0, n_bad = 0;
    logic [7:0] model [$];

    always #2.5 clk = ~clk;

    frame_capture_ctrl #(.DEPTH(DEPTH)) dut (.*);

    function automatic logic [7:0] exp_status(logic v, logic s, logic d);
        return {4'b0, d, 1'b0, s, v};
    endfunction

    function automatic int sat(int n);
        return (n > DEPTH) ? DEPTH : n;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic rd_reg(logic [6:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr_reg(logic [6:0] a, logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic check_size(string req, int exp);
        logic [7:0] lo, md, hi;
        rd_reg(7'h42, lo);
        rd_reg(7'h43, md);
        rd_reg(7'h44, hi);
        check(req, {8'h0, hi, md, lo}, 32'(exp));
        check("R8 high bit zero", 32'(hi[7]), 32'd0);
    endtask

    task automatic vs_pulse(logic with_byte, logic [7:0] b);
        @(negedge clk);
        cam_vsync = 1'b1; cam_valid = with_byte; cam_data = b;
        @(negedge clk);
        cam_vsync = 1'b0; cam_valid = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] b, bit keep);
        @(negedge clk);
        cam_valid = 1'b1; cam_data = b;
        if (keep && model.size() < DEPTH) model.push_back(b);
        @(negedge clk);
        cam_valid = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    task automatic drain_check(string req);
        logic [7:0] v;
        foreach (model[i]) begin
            rd_reg(7'h3D, v);
            check(req, 32'(v), 32'(model[i]));
        end
    endtask

    task automatic run_frame(int n, bit mid_start);
        logic [7:0] v;
        model.delete();
        wr_reg(7'h04, 8'h32);                    // start + both pointer resets
        rd_reg(7'h41, v);
        check("R5 start clears done", 32'(v[3]), 32'd0);
        send_byte(8'hEE, 1'b0);                  // R3: armed, not stored
        if (mid_start) wr_reg(7'h04, 8'h02);     // R6: start while armed
        vs_pulse(1'b0, 8'h00);
        for (int k = 0; k < n; k++) begin
            send_byte(8'($urandom), 1'b1);
            if (mid_start && k == n / 2) wr_reg(7'h04, 8'h02); // R6
        end
        rd_reg(7'h41, v);
        check("R4 done low while capturing", 32'(v[3]), 32'd0);
        vs_pulse(1'b1, 8'hA5);                   // R4: byte on edge dropped
        rd_reg(7'h41, v);
        check("R4 done after frame end", 32'(v[3]), 32'd1);
        check_size("R7/R8 stored count", sat(n));
        drain_check("R9 data order");
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        void'($urandom(32'd7361));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(7'h41, v);
        check("R1 status after reset", 32'(v), 32'd0);
        check_size("R1 size after reset", 0);
        // R10 unmapped
        rd_reg(7'h10, v);
        check("R10 unmapped reads zero", 32'(v), 32'd0);
        rd_reg(7'h01, v);
        check("R10 unmapped 0x01", 32'(v), 32'd0);

        // R2 live status bits
        @(negedge clk); cam_shutter = 1'b1; cam_vsync = 1'b1;
        rd_reg(7'h41, v);
        check("R2 vsync+shutter", 32'(v), 32'(exp_status(1, 1, 0)));
        @(negedge clk); cam_vsync = 1'b0; cam_shutter = 1'b0;
        rd_reg(7'h41, v);
        check("R2 cleared", 32'(v), 32'(exp_status(0, 0, 0)));

        // R3 idle bytes not stored
        send_byte(8'h11, 1'b0);
        send_byte(8'h22, 1'b0);
        vs_pulse(1'b0, 8'h00);
        send_byte(8'h33, 1'b0);
        check_size("R3 idle bytes ignored", 0);

        // directed saturation frame, R7
        run_frame(DEPTH + 10, 1'b0);
        // R5 done holds
        repeat (5) @(negedge clk);
        rd_reg(7'h41, v);
        check("R5 done held", 32'(v[3]), 32'd1);
        // R9 read pointer reset, then wrap
        wr_reg(7'h04, 8'h20);
        rd_reg(7'h3D, v);
        check("R9 rptr reset first byte", 32'(v), 32'(model[0]));
        // R7 write pointer reset
        wr_reg(7'h04, 8'h10);
        check_size("R7 wptr reset zero count", 0);
        // R5 clear
        wr_reg(7'h04, 8'h01);
        rd_reg(7'h41, v);
        check("R5 clear drops done", 32'(v[3]), 32'd0);

        // R6 start during armed/capture, then random frames
        run_frame(12, 1'b1);
        for (int f = 0; f < 8; f++) begin
            run_frame($urandom_range(0, 40), f[0]);
            if (f[1]) begin
                wr_reg(7'h04, 8'h01);
                rd_reg(7'h41, v);
                check("R5 clear after frame", 32'(v[3]), 32'd0);
            end
        end

        // R4 second edge after done does not restart storing
        model.delete();
        run_frame(5, 1'b0);
        vs_pulse(1'b0, 8'h00);
        send_byte(8'h77, 1'b0);
        check_size("R4 no store after done", 5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule